// File: doc/BRIEF.md
# Base-Mask Memory Request Router

This block decides which of eight destination ports a memory request is sent to. It holds a small set of routing descriptors that software programs. Each descriptor is one 64-bit register. It carries a 3-bit destination, a qualifier flag that looks at address bit 8, a 20-bit base and a 20-bit mask. For every request, each descriptor compares the masked page number (address bits [31:12]) with its base. When the qualifier is set, the descriptor also requires address bit 8 to be low.

When more than one descriptor hits, the lowest-numbered one wins. When none hits, the request goes to a default port chosen by a parameter, and a miss flag is raised. The routing answer is registered: it appears one clock after the request strobe, as a single-cycle pulse together with the port, the index of the winning descriptor and the miss flag.

The descriptors sit at consecutive register addresses starting at a parameterised base address. Writes take effect at the clock edge. Reads are combinational from the address.

Top module: `addr_route_top`

## Requirements
- R1: After reset every descriptor reads back 0x000000FF_FFF00000. This is destination 0, flag clear, base 0xFFFFF and mask 0. With those values no descriptor can hit, so every request is a miss until the descriptors are programmed.
- R2: Descriptor i is at register address REG_BASE+i (0x20 and 0x21 by default). A write stores all 64 bits, including the unused bits 59:40, and a read at that address returns exactly the value last written.
- R3: A register address outside REG_BASE..REG_BASE+NUM_DESC-1 reads as zero, and a write to it changes no descriptor.
- R4: A descriptor hits when (address[31:12] AND mask) equals base. The mask is bits 19:0 and the base is bits 39:20. The request is then sent to the destination in bits 63:61.
- R5: When the qualifier flag (bit 60) of a descriptor is 1, that descriptor hits only if address bit 8 is 0. When the flag is 0, address bit 8 is ignored.
- R6: When several descriptors hit, the lowest-numbered one decides the port, and rsp_hit_idx gives its index.
- R7: When no descriptor hits, rsp_port equals DEFAULT_PORT, rsp_miss is 1 and rsp_hit_idx is 0. On a hit, rsp_miss is 0.
- R8: rsp_valid is 1 in exactly the cycle after a cycle in which req_valid was 1. It stays 0 otherwise, including during and right after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_addr | input | REG_AW | Register address for reads and writes |
| reg_wr_en | input | 1 | Write strobe |
| reg_wdata | input | 64 | Write data |
| reg_rdata | output | 64 | Read data for reg_addr (combinational) |
| req_valid | input | 1 | Request strobe |
| req_addr | input | 32 | Physical address of the request |
| rsp_valid | output | 1 | Route result valid, one cycle after req_valid |
| rsp_port | output | 3 | Destination port |
| rsp_hit_idx | output | IDX_W | Index of the winning descriptor (0 on a miss) |
| rsp_miss | output | 1 | No descriptor hit; the default port was used |

## Verification
Directed requests cover four cases:
- The reset state, where every request must miss.
- An exact base match against a full mask, which separates a true compare from a partial one.
- Pairs of addresses that differ only in bit 8, with the qualifier set and then cleared, which isolate the qualifier.
- Two overlapping descriptors that both hit, which show that descriptor 0 wins and that descriptor 1 is still reachable when descriptor 0 misses.

Random descriptors with random masks are then paired with addresses that are either forced onto a descriptor's base or left fully random. This mixes hits, priority overlaps and misses, and all three are compared against a bench model of the masked compare.

// File: rtl/addr_route_pkg.sv
// Shared descriptor layout for the base-mask request router.
// Assumes a fixed 64-bit descriptor with 20-bit page fields.
package addr_route_pkg;

    localparam int DESC_W  = 64;
    localparam int PAGE_W  = 20;
    localparam int PORT_W  = 3;
    localparam int ADDR_W  = 32;

    // Field order matches the bit positions the hit logic decodes.
    typedef struct packed {
        logic [PORT_W-1:0] dest;   // 63:61
        logic              qual;   // 60
        logic [PAGE_W-1:0] spare;  // 59:40, stored only
        logic [PAGE_W-1:0] base;   // 39:20
        logic [PAGE_W-1:0] mask;   // 19:0
    } route_desc_t;

    localparam logic [DESC_W-1:0] DESC_RESET = 64'h0000_00FF_FFF0_0000;

endpackage

// File: rtl/route_desc_regs.sv
// Descriptor register file: NUM_DESC 64-bit registers at consecutive
// addresses from REG_BASE. Assumes one write per cycle and a
// combinational read; unmapped addresses read zero.
module route_desc_regs
    import addr_route_pkg::*;
#(
    parameter int          NUM_DESC = 2,
    parameter int          REG_AW   = 8,
    parameter int unsigned REG_BASE = 'h20
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [REG_AW-1:0]          reg_addr,
    input  logic                       reg_wr_en,
    input  logic [DESC_W-1:0]          reg_wdata,
    output logic [DESC_W-1:0]          reg_rdata,
    output route_desc_t [NUM_DESC-1:0] desc_q
);

    logic [NUM_DESC-1:0] sel;

    for (genvar g = 0; g < NUM_DESC; g++) begin : g_desc
        localparam int unsigned SLOT_ADDR = REG_BASE + g;

        // Decode whether the register address selects this slot.
        always_comb begin
            sel[g] = (reg_addr == SLOT_ADDR[REG_AW-1:0]);
        end

        // Hold one descriptor; load all 64 bits on a selected write.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                desc_q[g] <= route_desc_t'(DESC_RESET);
            end else if (reg_wr_en && sel[g]) begin
                desc_q[g] <= route_desc_t'(reg_wdata);
            end
        end
    end

    // Return the selected descriptor, or zero when nothing is selected.
    always_comb begin
        reg_rdata = '0;
        for (int i = 0; i < NUM_DESC; i++) begin
            if (sel[i]) begin
                reg_rdata = desc_q[i];
            end
        end
    end

endmodule

// File: rtl/route_desc_match.sv
// Hit test for one descriptor: masked page compare against the base,
// optionally blocked when address bit 8 is set. Purely combinational.
module route_desc_match
    import addr_route_pkg::*;
(
    input  route_desc_t        desc,
    input  logic [PAGE_W-1:0]  page,
    input  logic               addr_b8,
    output logic               hit
);

    logic page_eq;
    logic b8_ok;

    // Compare the masked page number against the programmed base.
    always_comb begin
        page_eq = ((page & desc.mask) == desc.base);
        b8_ok   = !(desc.qual && addr_b8);
        hit     = page_eq && b8_ok;
    end

endmodule

// File: rtl/route_prio_sel.sv
// Picks the lowest-numbered hitting descriptor and its destination;
// falls back to DEFAULT_PORT with a miss flag when none hits.
module route_prio_sel
    import addr_route_pkg::*;
#(
    parameter int          NUM_DESC     = 2,
    parameter int unsigned DEFAULT_PORT = 4,
    localparam int         IDX_W        = (NUM_DESC > 1) ? $clog2(NUM_DESC) : 1
) (
    input  logic [NUM_DESC-1:0]             hit_vec,
    input  logic [NUM_DESC-1:0][PORT_W-1:0] dest_vec,
    output logic [PORT_W-1:0]               port,
    output logic [IDX_W-1:0]                idx,
    output logic                            miss
);

    // Scan from the top down so the lowest hitting index is the one kept.
    always_comb begin
        port = DEFAULT_PORT[PORT_W-1:0];
        idx  = '0;
        miss = 1'b1;
        for (int i = NUM_DESC - 1; i >= 0; i--) begin
            if (hit_vec[i]) begin
                port = dest_vec[i];
                idx  = IDX_W'(i);
                miss = 1'b0;
            end
        end
    end

endmodule

// File: rtl/addr_route_top.sv
// Base-mask memory request router. Assumes a single-cycle request strobe.
// Produces a registered route result one clock after each request.
module addr_route_top
    import addr_route_pkg::*;
#(
    parameter int          NUM_DESC     = 2,
    parameter int          REG_AW       = 8,
    parameter int unsigned REG_BASE     = 'h20,
    parameter int unsigned DEFAULT_PORT = 4,
    localparam int         IDX_W        = (NUM_DESC > 1) ? $clog2(NUM_DESC) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [REG_AW-1:0]    reg_addr,
    input  logic                 reg_wr_en,
    input  logic [DESC_W-1:0]    reg_wdata,
    output logic [DESC_W-1:0]    reg_rdata,
    input  logic                 req_valid,
    input  logic [ADDR_W-1:0]    req_addr,
    output logic                 rsp_valid,
    output logic [PORT_W-1:0]    rsp_port,
    output logic [IDX_W-1:0]     rsp_hit_idx,
    output logic                 rsp_miss
);

    route_desc_t [NUM_DESC-1:0]      desc_q;
    logic [NUM_DESC-1:0]             hit_vec;
    logic [NUM_DESC-1:0][PORT_W-1:0] dest_vec;
    logic [PORT_W-1:0]               sel_port;
    logic [IDX_W-1:0]                sel_idx;
    logic                            sel_miss;
    logic                            unused_addr_bits;

    // Address bits outside the page field and bit 8 do not take part in routing.
    assign unused_addr_bits = ^{req_addr[11:9], req_addr[7:0]};

    route_desc_regs #(
        .NUM_DESC (NUM_DESC),
        .REG_AW   (REG_AW),
        .REG_BASE (REG_BASE)
    ) i_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_addr  (reg_addr),
        .reg_wr_en (reg_wr_en),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .desc_q    (desc_q)
    );

    for (genvar g = 0; g < NUM_DESC; g++) begin : g_match
        route_desc_match i_match (
            .desc    (desc_q[g]),
            .page    (req_addr[31:12]),
            .addr_b8 (req_addr[8]),
            .hit     (hit_vec[g])
        );
        assign dest_vec[g] = desc_q[g].dest;
    end

    route_prio_sel #(
        .NUM_DESC     (NUM_DESC),
        .DEFAULT_PORT (DEFAULT_PORT)
    ) i_prio (
        .hit_vec  (hit_vec),
        .dest_vec (dest_vec),
        .port     (sel_port),
        .idx      (sel_idx),
        .miss     (sel_miss)
    );

    // Register the route decision for the cycle after the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid   <= 1'b0;
            rsp_port    <= '0;
            rsp_hit_idx <= '0;
            rsp_miss    <= 1'b0;
        end else begin
            rsp_valid <= req_valid;
            if (req_valid) begin
                rsp_port    <= sel_port;
                rsp_hit_idx <= sel_idx;
                rsp_miss    <= sel_miss;
            end
        end
    end

endmodule

// File: rtl/addr_route_chk.sv
// Port-level assertions for addr_route_top, attached with bind.
module addr_route_chk
    import addr_route_pkg::*;
#(
    parameter int          NUM_DESC     = 2,
    parameter int          REG_AW       = 8,
    parameter int unsigned REG_BASE     = 'h20,
    parameter int unsigned DEFAULT_PORT = 4,
    parameter int          IDX_W        = 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic [REG_AW-1:0] reg_addr,
    input logic              reg_wr_en,
    input logic [DESC_W-1:0] reg_wdata,
    input logic [DESC_W-1:0] reg_rdata,
    input logic              req_valid,
    input logic              rsp_valid,
    input logic [PORT_W-1:0] rsp_port,
    input logic [IDX_W-1:0]  rsp_hit_idx,
    input logic              rsp_miss
);

    logic mapped;

    // Flag register addresses that fall inside the descriptor window.
    always_comb begin
        mapped = (int'(reg_addr) >= int'(REG_BASE)) &&
                 (int'(reg_addr) <  int'(REG_BASE) + NUM_DESC);
    end

    assert_rsp_after_req_R8: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    assert_no_rsp_without_req_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    assert_miss_default_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_miss) |-> (rsp_port == DEFAULT_PORT[PORT_W-1:0] && rsp_hit_idx == '0));

    assert_unmapped_reads_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !mapped |-> (reg_rdata == '0));

    assert_write_readback_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_en && mapped) |=> ((reg_addr != $past(reg_addr)) || (reg_rdata == $past(reg_wdata))));

endmodule

bind addr_route_top addr_route_chk #(
    .NUM_DESC     (NUM_DESC),
    .REG_AW       (REG_AW),
    .REG_BASE     (REG_BASE),
    .DEFAULT_PORT (DEFAULT_PORT),
    .IDX_W        (IDX_W)
) i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .reg_addr    (reg_addr),
    .reg_wr_en   (reg_wr_en),
    .reg_wdata   (reg_wdata),
    .reg_rdata   (reg_rdata),
    .req_valid   (req_valid),
    .rsp_valid   (rsp_valid),
    .rsp_port    (rsp_port),
    .rsp_hit_idx (rsp_hit_idx),
    .rsp_miss    (rsp_miss)
);

// File: tb/test_addr_route_top.sv
module test_addr_route_top;

    localparam logic [7:0]  BASE_A = 8'h20;
    localparam logic [2:0]  DEF    = 3'd4;
    localparam logic [63:0] RSTV   = 64'h0000_00FF_FFF0_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic        reg_wr_en = 1'b0;
    logic [63:0] reg_wdata = '0;
    logic [63:0] reg_rdata;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = '0;
    logic        rsp_valid;
    logic [2:0]  rsp_port;
    logic [0:0]  rsp_hit_idx;
    logic        rsp_miss;

    int n_tests = 0;
    int n_fail  = 0;
    logic done = 1'b0;
    logic [63:0] shadow [2];

    always #2 clk = ~clk;

    addr_route_top #(
        .NUM_DESC (2), .REG_AW (8), .REG_BASE ('h20), .DEFAULT_PORT (4)
    ) i_addr_route_top (
        .clk (clk), .rst_n (rst_n),
        .reg_addr (reg_addr), .reg_wr_en (reg_wr_en), .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .req_valid (req_valid), .req_addr (req_addr),
        .rsp_valid (rsp_valid), .rsp_port (rsp_port),
        .rsp_hit_idx (rsp_hit_idx), .rsp_miss (rsp_miss)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Model of R4..R7: {miss, idx, port}
    function automatic logic [4:0] exp_route(input logic [31:0] a);
        for (int i = 0; i < 2; i++) begin
            logic [63:0] d = shadow[i];
            if (((a[31:12] & d[19:0]) == d[39:20]) && !(d[60] && a[8]))
                return {1'b0, i[0], d[63:61]};
        end
        return {1'b1, 1'b0, DEF};
    endfunction

    task automatic reg_wr(input logic [7:0] a, input logic [63:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr_en = 1'b1;
        @(negedge clk);
        reg_wr_en = 1'b0;
        if (a == BASE_A) shadow[0] = d;
        if (a == BASE_A + 8'd1) shadow[1] = d;
    endtask

    task automatic reg_chk(input string req, input logic [7:0] a, input logic [63:0] exp);
        @(negedge clk);
        reg_addr = a;
        #1;
        check(req, reg_rdata, exp);
    endtask

    task automatic route(input string req, input logic [31:0] a);
        logic [4:0] e = exp_route(a);
        @(negedge clk);
        req_valid = 1'b1; req_addr = a;
        @(negedge clk);
        req_valid = 1'b0;
        check({req, " R8 valid"}, {63'd0, rsp_valid}, 64'd1);
        check(req, {59'd0, rsp_miss, rsp_hit_idx, rsp_port}, {59'd0, e});
    endtask

    initial begin
        shadow[0] = RSTV; shadow[1] = RSTV;
        repeat (4) @(negedge clk);
        check("R8 valid low in reset", {63'd0, rsp_valid}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R8 valid low after reset", {63'd0, rsp_valid}, 64'd0);
        reg_chk("R1 reset desc0", BASE_A, RSTV);
        reg_chk("R1 reset desc1", BASE_A + 8'd1, RSTV);
        route("R1 reset miss", 32'hFFFF_F000);
        route("R7 reset miss zero", 32'h0000_0000);

        // R2 full-width readback including unused bits
        reg_wr(BASE_A, 64'hABCD_EF12_3456_789A);
        reg_chk("R2 readback desc0", BASE_A, 64'hABCD_EF12_3456_789A);
        reg_wr(BASE_A + 8'd1, 64'h0FFF_FFF0_0000_0001);
        reg_chk("R2 readback desc1", BASE_A + 8'd1, 64'h0FFF_FFF0_0000_0001);

        // R3 unmapped accesses
        reg_chk("R3 unmapped read low", BASE_A - 8'd1, 64'd0);
        reg_chk("R3 unmapped read high", BASE_A + 8'd2, 64'd0);
        reg_wr(BASE_A + 8'd2, 64'hFFFF_FFFF_FFFF_FFFF);
        reg_wr(8'h00, 64'h1234_5678_9ABC_DEF0);
        reg_chk("R3 write ignored desc0", BASE_A, 64'hABCD_EF12_3456_789A);
        reg_chk("R3 write ignored desc1", BASE_A + 8'd1, 64'h0FFF_FFF0_0000_0001);

        // R4 exact match: desc0 dest 5, base 0x12345, full mask
        reg_wr(BASE_A, {3'd5, 1'b0, 20'd0, 20'h12345, 20'hFFFFF});
        reg_wr(BASE_A + 8'd1, RSTV);
        route("R4 exact hit", 32'h1234_5ABC);
        route("R4 one bit off miss", 32'h1234_4ABC);
        // R5 qualifier
        reg_wr(BASE_A, {3'd6, 1'b1, 20'd0, 20'h00A00, 20'hFFF00});
        route("R5 qual b8 low hits", 32'h00A4_50FF);
        route("R5 qual b8 high misses", 32'h00A4_5100);
        reg_wr(BASE_A, {3'd6, 1'b0, 20'd0, 20'h00A00, 20'hFFF00});
        route("R5 no qual b8 high hits", 32'h00A4_5100);
        // R6 priority: both hit, desc0 wins
        reg_wr(BASE_A, {3'd2, 1'b1, 20'd0, 20'h80000, 20'hF0000});
        reg_wr(BASE_A + 8'd1, {3'd7, 1'b0, 20'd0, 20'h80000, 20'hC0000});
        route("R6 both hit desc0 wins", 32'h8123_4000);
        route("R6 desc0 blocked desc1 wins", 32'h8123_4100);
        route("R6 desc1 only", 32'hB123_4000);
        route("R7 none hits", 32'h4000_0000);
        @(negedge clk);
        check("R8 no req no valid", {63'd0, rsp_valid}, 64'd0);

        // Random descriptors and requests
        for (int k = 0; k < 400; k++) begin
            if (k % 20 == 0) begin
                for (int j = 0; j < 2; j++) begin
                    logic [19:0] m = $urandom;
                    logic [19:0] b = $urandom;
                    if ($urandom % 4 != 0) b = b & m;
                    reg_wr(BASE_A + 8'(j),
                           {3'($urandom), 1'($urandom), 20'($urandom), b, m});
                end
            end
            begin
                logic [31:0] a = $urandom;
                int j = $urandom % 2;
                if ($urandom % 2 == 0)
                    a[31:12] = (a[31:12] & ~shadow[j][19:0]) | shadow[j][39:20];
                route("R4 R5 R6 R7 random", a);
            end
        end

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd1357));
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule